// File: doc/BRIEF.md
# Chase Test-Vector Syndrome Updater

In a low-complexity Chase decoder for a Reed-Solomon code over GF(8), the received word has a few unreliable symbols, and each one has a hard decision and a second-best decision. Every combination of those choices is a test vector. This block receives the syndromes of the all-hard-decision vector, S1..S4, together with a table of the unreliable points. The table gives each point's position and its two candidate symbols. The block then produces the syndromes of every other test vector without evaluating the received polynomial again.

The vectors are visited in reflected Gray-code order, so two consecutive vectors differ in exactly one point. For that point the block forms the symbol difference hd XOR sd. It multiplies the difference by α^(i·pos) and adds the product to syndrome Si. The syndromes rotate through a queue past a single GF adder, so each new syndrome set takes four clock cycles. Each completed set is presented with a one-cycle valid pulse and a test-vector mask. A downstream decoder can end the sequence early with a stop input once one of the vectors has decoded.

Top module: `chase_syn_updater`

## Requirements
- R1: While reset is asserted and after it is released, syn_valid is 0, tv_idx is 0 and syn_out is 0.
- R2: A load sampled at a clock edge captures syn_in, num_pts and the point table. After that same edge the block shows syn_valid=1, tv_idx=0 and syn_out equal to syn_in. The packing is S1 in bits [2:0] and Si in bits [3i-1:3i-3].
- R3: With num_pts=η between 1 and 3, a load is followed by exactly 2^η valid pulses. The pulses come 4g cycles after the load edge, for g = 0 .. 2^η-1, and no pulse follows the last one.
- R4: Pulse g carries tv_idx = g XOR (g>>1). Bit j of tv_idx set means that point j uses its second-best symbol.
- R5: At pulse g, let j be the bit in which tv_idx differs from the previous mask. Each Si becomes Si XOR (hd_j XOR sd_j)·α^(i·pos_j). Arithmetic is in GF(8) with polynomial x^3+x+1 and α=2. The exponent is taken modulo 7, so a position of 7 acts like position 0. Point j occupies bits [3j+2:3j] of pos_in, hd_in and sd_in.
- R6: A point whose hd and sd are equal leaves the syndromes unchanged in the set where it flips.
- R7: Stop sampled high at an edge while a sequence runs (and load is low) ends the sequence. No further pulse follows, and this includes a pulse that would have completed at that same edge.
- R8: Stop has no effect while no sequence runs. A load and a stop at the same edge act as a plain load.
- R9: A load while a sequence runs discards that sequence and starts over from the new inputs.
- R10: A load with num_pts=0 gives the single pulse of R2 and nothing after it.
- R11: syn_valid is high for one cycle only per completed set, and syn_out holds its last value while syn_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Capture first-vector syndromes and point table, start sequence |
| stop | input | 1 | Abort the running sequence |
| num_pts | input | 2 | Number of unreliable points η (0..3) |
| syn_in | input | 12 | First test vector's syndromes S1..S4 |
| pos_in | input | 9 | Positions of points 0..2 |
| hd_in | input | 9 | Hard-decision symbols of points 0..2 |
| sd_in | input | 9 | Second-best symbols of points 0..2 |
| syn_out | output | 12 | Syndromes of the current test vector |
| syn_valid | output | 1 | One-cycle pulse per completed syndrome set |
| tv_idx | output | 3 | Test-vector mask (Gray code) of the set on syn_out |

## Verification
Two events can land on the same clock edge. A stop can arrive on the edge where a four-cycle update would finish, and a load can arrive together with a stop. To provoke the first case, the bench raises stop on exactly the fourth edge after a load. It is judged correct when no second pulse appears and syn_out keeps the first set. A load with stop held high must start a full sequence. A behavioural model of the pulse schedule and the GF update is compared with the outputs on every cycle, and pulse counts per scenario are checked as well.

// File: rtl/chase_pkg.sv
package chase_pkg;

  localparam int GF_M = 3;
  localparam int GF_N = (1 << GF_M) - 1;
  localparam logic [GF_M-1:0] GF_RED = 3'b011;  // x^3 = x + 1
  localparam logic [GF_M-1:0] GF_ONE = 3'b001;
  localparam logic [GF_M-1:0] GF_ALPHA = 3'b010;

  typedef logic [GF_M-1:0] sym_t;

  // shift-and-add multiply with reduction
  function automatic sym_t gf_mul(sym_t a, sym_t b);
    sym_t acc;
    sym_t sh;
    acc = '0;
    sh  = a;
    for (int k = 0; k < GF_M; k++) begin
      if (b[k]) acc = acc ^ sh;
      sh = sh[GF_M-1] ? ((sh << 1) ^ GF_RED) : (sh << 1);
    end
    return acc;
  endfunction

  // alpha^e, exponent reduced modulo GF_N
  function automatic sym_t gf_pow(sym_t e);
    sym_t r;
    int   lim;
    r   = GF_ONE;
    lim = int'(e) % GF_N;
    for (int k = 0; k < GF_N; k++) begin
      if (k < lim) r = gf_mul(r, GF_ALPHA);
    end
    return r;
  endfunction

  // index of the lowest set bit (0 when none)
  function automatic int first_set(int v);
    int r;
    r = 0;
    for (int k = 31; k >= 0; k--) begin
      if (v[k]) r = k;
    end
    return r;
  endfunction

endpackage

// File: rtl/chase_tv_seq.sv
module chase_tv_seq #(
  parameter int NSYN    = 4,
  parameter int MAX_PTS = 3,
  localparam int CW  = (NSYN > 1) ? $clog2(NSYN) : 1,
  localparam int NPW = $clog2(MAX_PTS + 1),
  localparam int GW  = MAX_PTS + 1,
  localparam int FW  = (MAX_PTS > 1) ? $clog2(MAX_PTS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               stop,
  input  logic [NPW-1:0]     num_pts,
  output logic               shift_en,
  output logic               step_last,
  output logic [FW-1:0]      flip_idx,
  output logic [MAX_PTS-1:0] tv_next
);
  import chase_pkg::*;

  logic           active_q, active_n;
  logic [CW-1:0]  cnt_q, cnt_n;
  logic [GW-1:0]  gcnt_q, gcnt_n;
  logic [NPW-1:0] npts_q, npts_n;
  logic [FW-1:0]  fidx_q, fidx_n;

  logic [NPW-1:0] npts_ld;
  logic [GW-1:0]  last_g;
  logic [GW-1:0]  g_inc;
  logic [GW-1:0]  gray_w;

  always_comb begin
    npts_ld   = (int'(num_pts) > MAX_PTS) ? NPW'(MAX_PTS) : num_pts;
    last_g    = (GW'(1) << npts_q) - GW'(1);
    g_inc     = gcnt_q + GW'(1);
    gray_w    = g_inc ^ (g_inc >> 1);
    tv_next   = gray_w[MAX_PTS-1:0];
    shift_en  = active_q && !stop && !load;
    step_last = shift_en && (cnt_q == CW'(NSYN - 1));
    flip_idx  = fidx_q;
  end

  always_comb begin
    active_n = active_q;
    cnt_n    = cnt_q;
    gcnt_n   = gcnt_q;
    npts_n   = npts_q;
    fidx_n   = fidx_q;
    if (load) begin
      active_n = (npts_ld != '0);
      npts_n   = npts_ld;
      cnt_n    = '0;
      gcnt_n   = '0;
      fidx_n   = '0;
    end else if (shift_en) begin
      if (cnt_q == CW'(NSYN - 1)) begin
        cnt_n  = '0;
        gcnt_n = g_inc;
        if (g_inc == last_g) active_n = 1'b0;
        else fidx_n = FW'(first_set(int'(g_inc) + 1));
      end else begin
        cnt_n = cnt_q + CW'(1);
      end
    end else if (active_q && stop) begin
      active_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      gcnt_q   <= '0;
      npts_q   <= '0;
      fidx_q   <= '0;
    end else begin
      active_q <= active_n;
      cnt_q    <= cnt_n;
      gcnt_q   <= gcnt_n;
      npts_q   <= npts_n;
      fidx_q   <= fidx_n;
    end
  end

endmodule

// File: rtl/chase_pt_table.sv
module chase_pt_table #(
  parameter int MAX_PTS = 3,
  localparam int M  = chase_pkg::GF_M,
  localparam int TW = MAX_PTS * M,
  localparam int FW = (MAX_PTS > 1) ? $clog2(MAX_PTS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [TW-1:0]   pos_in,
  input  logic [TW-1:0]   hd_in,
  input  logic [TW-1:0]   sd_in,
  input  logic [FW-1:0]   flip_idx,
  output chase_pkg::sym_t diff,
  output chase_pkg::sym_t apos
);
  import chase_pkg::*;

  sym_t pos_q [MAX_PTS];
  sym_t hd_q  [MAX_PTS];
  sym_t sd_q  [MAX_PTS];

  for (genvar p = 0; p < MAX_PTS; p++) begin : g_pt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pos_q[p] <= '0;
        hd_q[p]  <= '0;
        sd_q[p]  <= '0;
      end else if (load) begin
        pos_q[p] <= pos_in[p*M +: M];
        hd_q[p]  <= hd_in[p*M +: M];
        sd_q[p]  <= sd_in[p*M +: M];
      end
    end
  end

  sym_t sel_pos;
  sym_t sel_hd;
  sym_t sel_sd;

  always_comb begin
    sel_pos = '0;
    sel_hd  = '0;
    sel_sd  = '0;
    for (int k = 0; k < MAX_PTS; k++) begin
      if (int'(flip_idx) == k) begin
        sel_pos = pos_q[k];
        sel_hd  = hd_q[k];
        sel_sd  = sd_q[k];
      end
    end
    diff = sel_hd ^ sel_sd;
    apos = gf_pow(sel_pos);
  end

endmodule

// File: rtl/chase_syn_queue.sv
module chase_syn_queue #(
  parameter int NSYN    = 4,
  parameter int MAX_PTS = 3,
  localparam int M  = chase_pkg::GF_M,
  localparam int NW = NSYN * M
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [NW-1:0]      syn_in,
  input  logic               shift_en,
  input  logic               step_last,
  input  chase_pkg::sym_t    diff,
  input  chase_pkg::sym_t    apos,
  input  logic [MAX_PTS-1:0] tv_next,
  output logic [NW-1:0]      syn_out,
  output logic               syn_valid,
  output logic [MAX_PTS-1:0] tv_idx
);
  import chase_pkg::*;

  logic [NW-1:0]      q_q, q_n;
  sym_t               pw_q, pw_n;
  logic [NW-1:0]      out_q, out_n;
  logic               vld_q, vld_n;
  logic [MAX_PTS-1:0] tv_q, tv_n;

  sym_t          pw_step;
  sym_t          term;
  logic [NW-1:0] rot;

  always_comb begin
    pw_step = gf_mul(pw_q, apos);
    term    = gf_mul(diff, pw_step);
  end

  // head (S at the adder) sits in the low symbol; updated value re-enters at the tail
  if (NSYN == 1) begin : g_rot_one
    assign rot = q_q ^ term;
  end else begin : g_rot_many
    assign rot = {q_q[M-1:0] ^ term, q_q[NW-1:M]};
  end

  always_comb begin
    q_n   = q_q;
    pw_n  = pw_q;
    out_n = out_q;
    tv_n  = tv_q;
    vld_n = 1'b0;
    if (load) begin
      q_n   = syn_in;
      pw_n  = GF_ONE;
      out_n = syn_in;
      tv_n  = '0;
      vld_n = 1'b1;
    end else if (shift_en) begin
      q_n  = rot;
      pw_n = step_last ? GF_ONE : pw_step;
      if (step_last) begin
        out_n = rot;
        tv_n  = tv_next;
        vld_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q   <= '0;
      pw_q  <= GF_ONE;
      out_q <= '0;
      vld_q <= 1'b0;
      tv_q  <= '0;
    end else begin
      q_q   <= q_n;
      pw_q  <= pw_n;
      out_q <= out_n;
      vld_q <= vld_n;
      tv_q  <= tv_n;
    end
  end

  assign syn_out   = out_q;
  assign syn_valid = vld_q;
  assign tv_idx    = tv_q;

endmodule

// File: rtl/chase_syn_updater.sv
module chase_syn_updater #(
  parameter int NSYN    = 4,
  parameter int MAX_PTS = 3,
  localparam int M   = chase_pkg::GF_M,
  localparam int NW  = NSYN * M,
  localparam int TW  = MAX_PTS * M,
  localparam int NPW = $clog2(MAX_PTS + 1),
  localparam int FW  = (MAX_PTS > 1) ? $clog2(MAX_PTS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               stop,
  input  logic [NPW-1:0]     num_pts,
  input  logic [NW-1:0]      syn_in,
  input  logic [TW-1:0]      pos_in,
  input  logic [TW-1:0]      hd_in,
  input  logic [TW-1:0]      sd_in,
  output logic [NW-1:0]      syn_out,
  output logic               syn_valid,
  output logic [MAX_PTS-1:0] tv_idx
);
  import chase_pkg::*;

  logic               shift_en;
  logic               step_last;
  logic [FW-1:0]      flip_idx;
  logic [MAX_PTS-1:0] tv_next;
  sym_t               diff;
  sym_t               apos;

  chase_tv_seq #(.NSYN(NSYN), .MAX_PTS(MAX_PTS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .stop      (stop),
    .num_pts   (num_pts),
    .shift_en  (shift_en),
    .step_last (step_last),
    .flip_idx  (flip_idx),
    .tv_next   (tv_next)
  );

  chase_pt_table #(.MAX_PTS(MAX_PTS)) u_tbl (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .pos_in   (pos_in),
    .hd_in    (hd_in),
    .sd_in    (sd_in),
    .flip_idx (flip_idx),
    .diff     (diff),
    .apos     (apos)
  );

  chase_syn_queue #(.NSYN(NSYN), .MAX_PTS(MAX_PTS)) u_que (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .syn_in    (syn_in),
    .shift_en  (shift_en),
    .step_last (step_last),
    .diff      (diff),
    .apos      (apos),
    .tv_next   (tv_next),
    .syn_out   (syn_out),
    .syn_valid (syn_valid),
    .tv_idx    (tv_idx)
  );

endmodule

// File: rtl/chase_syn_updater_chk.sv
module chase_syn_updater_chk #(
  parameter int NSYN    = 4,
  parameter int MAX_PTS = 3,
  localparam int NW = NSYN * chase_pkg::GF_M
) (
  input logic               clk,
  input logic               rst_n,
  input logic               load,
  input logic               stop,
  input logic [NW-1:0]      syn_in,
  input logic [NW-1:0]      syn_out,
  input logic               syn_valid,
  input logic [MAX_PTS-1:0] tv_idx
);

  logic [MAX_PTS-1:0] prev_tv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_tv <= '0;
    else if (syn_valid) prev_tv <= tv_idx;
  end

  // R2
  load_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (syn_valid && tv_idx == '0 && syn_out == $past(syn_in)));

  // R7
  stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !load) |=> !syn_valid);

  // R11
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (syn_valid && !load) |=> !syn_valid);

  // R11
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !syn_valid |-> $stable(syn_out));

  // R4
  gray_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (syn_valid && tv_idx != '0) |-> ($countones(tv_idx ^ prev_tv) == 1));

endmodule

bind chase_syn_updater chase_syn_updater_chk #(.NSYN(NSYN), .MAX_PTS(MAX_PTS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .load      (load),
  .stop      (stop),
  .syn_in    (syn_in),
  .syn_out   (syn_out),
  .syn_valid (syn_valid),
  .tv_idx    (tv_idx)
);

// File: tb/chase_syn_updater_tb.sv
module chase_syn_updater_tb;

  localparam int NSYN = 4;
  localparam int MAXP = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic        stop = 1'b0;
  logic [1:0]  num_pts = '0;
  logic [11:0] syn_in = '0;
  logic [8:0]  pos_in = '0;
  logic [8:0]  hd_in = '0;
  logic [8:0]  sd_in = '0;
  logic [11:0] syn_out;
  logic        syn_valid;
  logic [2:0]  tv_idx;

  always #2.5ns clk = ~clk;

  chase_syn_updater u_dut (
    .clk(clk), .rst_n(rst_n), .load(load), .stop(stop), .num_pts(num_pts),
    .syn_in(syn_in), .pos_in(pos_in), .hd_in(hd_in), .sd_in(sd_in),
    .syn_out(syn_out), .syn_valid(syn_valid), .tv_idx(tv_idx)
  );

  int    checks = 0;
  int    fails = 0;
  int    pulses = 0;
  string cur_req = "R1";

  // GF(8) log/antilog tables for the reference model
  int alog [7];
  int lg   [8];
  initial begin
    int v;
    v = 1;
    for (int k = 0; k < 7; k++) begin
      alog[k] = v;
      lg[v] = k;
      v = v << 1;
      if (v > 7) v = v ^ 11;
    end
    lg[0] = 0;
  end

  function automatic int fmul(int a, int b);
    if (a == 0 || b == 0) return 0;
    return alog[(lg[a] + lg[b]) % 7];
  endfunction

  function automatic int tz(int v);
    for (int k = 0; k < 32; k++) if (v[k]) return k;
    return 0;
  endfunction

  // behavioural reference model
  int m_syn [4];
  int m_pos [3];
  int m_hd  [3];
  int m_sd  [3];
  int m_n = 0, m_k = 0, m_g = 0;
  bit m_act = 0;
  bit e_v = 0;
  int e_tv = 0;
  int e_syn [4] = '{0, 0, 0, 0};

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; e_v = 0; e_tv = 0;
      for (int i = 0; i < 4; i++) e_syn[i] = 0;
    end else if (load) begin
      for (int i = 0; i < 4; i++) m_syn[i] = int'(syn_in[i*3 +: 3]);
      for (int p = 0; p < 3; p++) begin
        m_pos[p] = int'(pos_in[p*3 +: 3]);
        m_hd[p]  = int'(hd_in[p*3 +: 3]);
        m_sd[p]  = int'(sd_in[p*3 +: 3]);
      end
      m_n = int'(num_pts);
      m_k = 0; m_g = 0;
      m_act = (m_n > 0);
      e_v = 1; e_tv = 0;
      for (int i = 0; i < 4; i++) e_syn[i] = m_syn[i];
    end else if (m_act && stop) begin
      m_act = 0; e_v = 0;
    end else if (m_act) begin
      e_v = 0;
      m_k++;
      if (m_k == NSYN) begin
        int j, d;
        m_k = 0;
        m_g++;
        j = tz(m_g);
        d = m_hd[j] ^ m_sd[j];
        for (int i = 1; i <= 4; i++)
          m_syn[i-1] = m_syn[i-1] ^ fmul(d, alog[(i * m_pos[j]) % 7]);
        e_v = 1;
        e_tv = m_g ^ (m_g >> 1);
        for (int i = 0; i < 4; i++) e_syn[i] = m_syn[i];
        if (m_g == (1 << m_n) - 1) m_act = 0;
      end
    end else begin
      e_v = 0;
    end
  end

  // per-cycle comparison, away from the active edge (also covers R11 holding)
  always @(negedge clk) begin
    logic [11:0] exp_out;
    for (int i = 0; i < 4; i++) exp_out[i*3 +: 3] = 3'(e_syn[i]);
    checks++;
    if (syn_valid !== e_v || syn_out !== exp_out || (e_v && tv_idx !== 3'(e_tv))) begin
      fails++;
      $display("FAIL %s/R11 t=%0t: valid=%0b tv=%0d syn=%h expected valid=%0b tv=%0d syn=%h",
               cur_req, $time, syn_valid, tv_idx, syn_out, e_v, e_tv, exp_out);
    end
    if (syn_valid === 1'b1) pulses++;
  end

  task automatic check_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_load(input int n, input logic st);
    @(negedge clk);
    load = 1'b1; stop = st; num_pts = 2'(n);
    syn_in = 12'($urandom); pos_in = 9'($urandom);
    hd_in = 9'($urandom); sd_in = 9'($urandom);
    @(negedge clk);
    load = 1'b0; stop = 1'b0;
  endtask

  task automatic wait_cyc(input int c);
    repeat (c) @(negedge clk);
  endtask

  task automatic pulse_stop();
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
  endtask

  initial begin
    #1ms;
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1 reset state
    cur_req = "R1";
    wait_cyc(3);
    check_eq("R1 valid", int'(syn_valid), 0);
    check_eq("R1 syn_out", int'(syn_out), 0);
    rst_n = 1'b1;
    wait_cyc(2);
    check_eq("R1 tv_idx", int'(tv_idx), 0);

    // R2 R3 R4 R5: two points
    cur_req = "R3";
    pulses = 0;
    do_load(2, 1'b0);
    wait_cyc(14);
    check_eq("R3 pulses n=2", pulses, 4);

    // R5 three points, position 7 wraps to 0
    cur_req = "R5";
    pulses = 0;
    @(negedge clk);
    load = 1'b1; num_pts = 2'd3; syn_in = 12'h5a3;
    pos_in = {3'd5, 3'd0, 3'd7}; hd_in = {3'd3, 3'd6, 3'd1}; sd_in = {3'd4, 3'd2, 3'd7};
    @(negedge clk);
    load = 1'b0;
    wait_cyc(32);
    check_eq("R3 pulses n=3", pulses, 8);

    // R6 equal decisions on point 1
    cur_req = "R6";
    @(negedge clk);
    load = 1'b1; num_pts = 2'd2; syn_in = 12'h3c7;
    pos_in = {3'd0, 3'd4, 3'd2}; hd_in = {3'd0, 3'd5, 3'd3}; sd_in = {3'd0, 3'd5, 3'd6};
    @(negedge clk);
    load = 1'b0;
    wait_cyc(16);

    // R10 no unreliable points
    cur_req = "R10";
    pulses = 0;
    do_load(0, 1'b0);
    wait_cyc(8);
    check_eq("R10 pulses n=0", pulses, 1);

    // R7 stop on the edge where the first update completes
    cur_req = "R7";
    pulses = 0;
    do_load(3, 1'b0);
    wait_cyc(3);
    pulse_stop();
    wait_cyc(12);
    check_eq("R7 stop at completion edge", pulses, 1);

    // R7 stop in the middle of the second update
    pulses = 0;
    do_load(3, 1'b0);
    wait_cyc(5);
    pulse_stop();
    wait_cyc(12);
    check_eq("R7 stop mid update", pulses, 2);

    // R8 stop while idle, then load with stop together
    cur_req = "R8";
    pulse_stop();
    wait_cyc(3);
    pulses = 0;
    do_load(2, 1'b1);
    wait_cyc(16);
    check_eq("R8 load with stop", pulses, 4);

    // R9 restart during a run
    cur_req = "R9";
    pulses = 0;
    do_load(3, 1'b0);
    wait_cyc(5);
    do_load(2, 1'b0);
    wait_cyc(16);
    check_eq("R9 restart pulses", pulses, 6);

    // R5 several random runs
    cur_req = "R5";
    for (int r = 0; r < 20; r++) begin
      do_load(1 + (r % 3), 1'b0);
      wait_cyc(34);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule